// File: doc/BRIEF.md
# Comparator result capture router

This block takes the digital decisions of two analog front-end comparators during a timed scan slot and files each decision into a flag bit. In each slot a capture-enable window (`arm_i`) lets a per-front-end hold register collect a high comparator result. A stop strobe (`stop_i`) then copies that held value into output flags. The stop strobe is edge-detected inside the block, so each slot writes once. Each comparator has its own polarity control, applied before the value is held.

Three routing modes pick the destination. In normal mode a 2-bit channel code writes the front-end 1 result into one of flags 0 to 3 and the front-end 2 result into the matching bit among flags 4 to 7. In test mode the channel code plays no part, and the front-end 1 result goes to one of two test flags chosen by a slot select. In envelope mode one front-end 1 input is spread over flags 0 to 3 across successive slots, with the channel code naming the bit; the upper flags are left untouched. Test mode takes priority over envelope mode. Flags that are not selected keep their values.

All inputs are synchronous to `clk`. The reset is synchronous and active high.

Top module: `cmp_capture_router`

## Requirements
- R1: While `rst` is high at a clock edge, all of `flags_o`, `test_flags_o`, both hold registers and the stop history are cleared to 0 after that edge.
- R2: A front-end hold register becomes 1 at an edge where `arm_i` is 1 and that front-end's effective comparator value is 1. It stays 1 while `arm_i` remains 1. It is 0 after any edge where `arm_i` is 0.
- R3: The effective comparator value is `cmp_a_i ^ inv_a_i` for front-end 1 and `cmp_b_i ^ inv_b_i` for front-end 2.
- R4: A write happens only at an edge where `stop_i` is 1 and `stop_i` was 0 at the previous edge (0 after reset). The value written is the hold register as it stood before that edge. Keeping `stop_i` high writes nothing more. With no write, all outputs hold their values.
- R5: In normal mode (`test_mode_i`=0, `env_mode_i`=0), a write with channel code c sets `flags_o[c]` to the front-end 1 hold value and `flags_o[4+c]` to the front-end 2 hold value. All other flags keep their values.
- R6: In test mode (`test_mode_i`=1), a write sets `test_flags_o[test_slot_i]` to the front-end 1 hold value. `chan_i` and `env_mode_i` are ignored, and `flags_o` and the other test flag keep their values.
- R7: In envelope mode (`test_mode_i`=0, `env_mode_i`=1), a write sets `flags_o[chan_i]` to the front-end 1 hold value. `flags_o[7:4]` keep their values.
- R8: Outside test mode, writes never change `test_flags_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_a_i | input | 1 | Front-end 1 comparator decision |
| cmp_b_i | input | 1 | Front-end 2 comparator decision |
| inv_a_i | input | 1 | Invert front-end 1 decision |
| inv_b_i | input | 1 | Invert front-end 2 decision |
| arm_i | input | 1 | Capture-enable window for the slot |
| stop_i | input | 1 | Slot stop strobe; its rising edge writes |
| chan_i | input | 2 | Channel code selecting the flag index |
| test_mode_i | input | 1 | 1 routes to test flags |
| test_slot_i | input | 1 | Selects which test flag receives the result |
| env_mode_i | input | 1 | Envelope mode for front-end 1 |
| flags_o | output | 8 | Main result flags (0-3 front-end 1, 4-7 front-end 2) |
| test_flags_o | output | 2 | Test result flags |

## Verification
A behavioural reference model in the bench follows every clock. Directed slots come first. Short and long arm windows, and a comparator pulse that ends before the window does, show that the hold register keeps a result instead of following the comparator. Inverted polarity on one front-end only shows the two polarity controls are separate. A stop held high for several cycles shows edge detection and not level detection. The three routing modes are each run with all four channel codes and both slot selects, which separates the destination decoding from the keep-other-bits behaviour. A long random run then mixes all inputs and the reset, so writes land mid-window and modes change between slots.

// File: rtl/cmp_cr_pkg.sv
package cmp_cr_pkg;

  typedef enum logic [1:0] {
    RM_NORMAL   = 2'd0,
    RM_ENVELOPE = 2'd1,
    RM_TEST     = 2'd2
  } route_mode_e;

  // Test selection has priority over envelope selection.
  function automatic route_mode_e decode_mode(input logic test_mode, input logic env_mode);
    if (test_mode)     return RM_TEST;
    else if (env_mode) return RM_ENVELOPE;
    else               return RM_NORMAL;
  endfunction

endpackage

// File: rtl/cmp_cr_hold.sv
// One front-end hold register: collects a high decision while the window is open.
module cmp_cr_hold (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  input  logic cmp_i,
  input  logic inv_i,
  output logic hold_o
);
  logic eff;
  logic hold_q;

  assign eff = cmp_i ^ inv_i;

  always_ff @(posedge clk) begin
    if (rst)        hold_q <= 1'b0;
    else if (arm_i) hold_q <= hold_q | eff;
    else            hold_q <= 1'b0;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/cmp_cr_edge.sv
// Rising-edge detector against a registered copy of the strobe.
module cmp_cr_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig_i,
  output logic rise_o,
  output logic sig_q_o
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (rst) sig_q <= 1'b0;
    else     sig_q <= sig_i;
  end

  assign rise_o  = sig_i & ~sig_q;
  assign sig_q_o = sig_q;
endmodule

// File: rtl/cmp_cr_route.sv
// Destination decoder: turns mode, code and slot into write masks and data.
module cmp_cr_route
  import cmp_cr_pkg::*;
#(
  parameter int FE_BITS = 4,
  parameter int N_TEST  = 2,
  localparam int CODE_W = $clog2(FE_BITS),
  localparam int SLOT_W = (N_TEST > 1) ? $clog2(N_TEST) : 1,
  localparam int MAIN_W = 2 * FE_BITS
) (
  input  logic              rise_i,
  input  route_mode_e       mode_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [1:0]        hold_i,
  output logic [MAIN_W-1:0] main_we_o,
  output logic [MAIN_W-1:0] main_wd_o,
  output logic [N_TEST-1:0] test_we_o,
  output logic [N_TEST-1:0] test_wd_o
);
  logic upper_en;
  logic lower_en;

  always_comb begin
    lower_en = rise_i && (mode_i != RM_TEST);
    upper_en = rise_i && (mode_i == RM_NORMAL);
  end

  for (genvar g = 0; g < FE_BITS; g++) begin : g_main
    always_comb begin
      main_we_o[g]           = lower_en && (code_i == CODE_W'(g));
      main_we_o[FE_BITS + g] = upper_en && (code_i == CODE_W'(g));
      main_wd_o[g]           = hold_i[0];
      main_wd_o[FE_BITS + g] = hold_i[1];
    end
  end

  for (genvar t = 0; t < N_TEST; t++) begin : g_test
    always_comb begin
      test_we_o[t] = rise_i && (mode_i == RM_TEST) && (slot_i == SLOT_W'(t));
      test_wd_o[t] = hold_i[0];
    end
  end
endmodule

// File: rtl/cmp_capture_router.sv
module cmp_capture_router
  import cmp_cr_pkg::*;
#(
  parameter int FE_BITS = 4,
  parameter int N_TEST  = 2,
  localparam int CODE_W = $clog2(FE_BITS),
  localparam int SLOT_W = (N_TEST > 1) ? $clog2(N_TEST) : 1,
  localparam int MAIN_W = 2 * FE_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_a_i,
  input  logic              cmp_b_i,
  input  logic              inv_a_i,
  input  logic              inv_b_i,
  input  logic              arm_i,
  input  logic              stop_i,
  input  logic [CODE_W-1:0] chan_i,
  input  logic              test_mode_i,
  input  logic [SLOT_W-1:0] test_slot_i,
  input  logic              env_mode_i,
  output logic [MAIN_W-1:0] flags_o,
  output logic [N_TEST-1:0] test_flags_o
);
  logic [1:0]        hold_w;
  logic [1:0]        cmp_w;
  logic [1:0]        inv_w;
  logic              rise_w;
  logic              stop_q_w;
  route_mode_e       mode_w;
  logic [MAIN_W-1:0] main_we;
  logic [MAIN_W-1:0] main_wd;
  logic [N_TEST-1:0] test_we;
  logic [N_TEST-1:0] test_wd;
  logic [MAIN_W-1:0] flags_q;
  logic [N_TEST-1:0] test_q;

  assign cmp_w  = {cmp_b_i, cmp_a_i};
  assign inv_w  = {inv_b_i, inv_a_i};
  assign mode_w = decode_mode(test_mode_i, env_mode_i);

  for (genvar f = 0; f < 2; f++) begin : g_fe
    cmp_cr_hold u_hold (
      .clk    (clk),
      .rst    (rst),
      .arm_i  (arm_i),
      .cmp_i  (cmp_w[f]),
      .inv_i  (inv_w[f]),
      .hold_o (hold_w[f])
    );
  end

  cmp_cr_edge u_stop (
    .clk     (clk),
    .rst     (rst),
    .sig_i   (stop_i),
    .rise_o  (rise_w),
    .sig_q_o (stop_q_w)
  );

  cmp_cr_route #(.FE_BITS(FE_BITS), .N_TEST(N_TEST)) u_route (
    .rise_i    (rise_w),
    .mode_i    (mode_w),
    .code_i    (chan_i),
    .slot_i    (test_slot_i),
    .hold_i    (hold_w),
    .main_we_o (main_we),
    .main_wd_o (main_wd),
    .test_we_o (test_we),
    .test_wd_o (test_wd)
  );

  for (genvar b = 0; b < MAIN_W; b++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flags_q[b] <= 1'b0;
      else if (main_we[b]) flags_q[b] <= main_wd[b];
    end
  end

  for (genvar t = 0; t < N_TEST; t++) begin : g_tflag
    always_ff @(posedge clk) begin
      if (rst)             test_q[t] <= 1'b0;
      else if (test_we[t]) test_q[t] <= test_wd[t];
    end
  end

  assign flags_o      = flags_q;
  assign test_flags_o = test_q;
endmodule

// File: rtl/cmp_cr_checker.sv
module cmp_cr_checker #(
  parameter int FE_BITS = 4,
  parameter int N_TEST  = 2,
  localparam int CODE_W = $clog2(FE_BITS),
  localparam int SLOT_W = (N_TEST > 1) ? $clog2(N_TEST) : 1,
  localparam int MAIN_W = 2 * FE_BITS
) (
  input logic              clk,
  input logic              rst,
  input logic              arm_i,
  input logic              stop_i,
  input logic              stop_q,
  input logic              test_mode_i,
  input logic              env_mode_i,
  input logic [CODE_W-1:0] chan_i,
  input logic [SLOT_W-1:0] test_slot_i,
  input logic [1:0]        hold,
  input logic [MAIN_W-1:0] flags_o,
  input logic [N_TEST-1:0] test_flags_o
);
  logic rise;
  assign rise = stop_i && !stop_q;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (flags_o == '0) && (test_flags_o == '0) && (hold == 2'b00));

  a_r2_window_closed_clears: assert property (@(posedge clk) disable iff (rst)
    !arm_i |=> (hold == 2'b00));

  a_r2_hold_sticks: assert property (@(posedge clk) disable iff (rst)
    (arm_i && hold[0]) |=> hold[0]);

  a_r4_no_edge_no_write: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(flags_o) && $stable(test_flags_o));

  a_r5_normal_lower: assert property (@(posedge clk) disable iff (rst)
    (rise && !test_mode_i && !env_mode_i) |=>
      (flags_o[$past(chan_i)] == $past(hold[0])) &&
      (flags_o[FE_BITS + $past(chan_i)] == $past(hold[1])));

  a_r6_test_main_kept: assert property (@(posedge clk) disable iff (rst)
    (rise && test_mode_i) |=>
      $stable(flags_o) && (test_flags_o[$past(test_slot_i)] == $past(hold[0])));

  a_r7_env_upper_kept: assert property (@(posedge clk) disable iff (rst)
    (rise && !test_mode_i && env_mode_i) |=>
      $stable(flags_o[MAIN_W-1:FE_BITS]) && (flags_o[$past(chan_i)] == $past(hold[0])));

  a_r8_test_flags_kept: assert property (@(posedge clk) disable iff (rst)
    !test_mode_i |=> $stable(test_flags_o));
endmodule

bind cmp_capture_router cmp_cr_checker #(.FE_BITS(FE_BITS), .N_TEST(N_TEST)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .arm_i        (arm_i),
  .stop_i       (stop_i),
  .stop_q       (stop_q_w),
  .test_mode_i  (test_mode_i),
  .env_mode_i   (env_mode_i),
  .chan_i       (chan_i),
  .test_slot_i  (test_slot_i),
  .hold         (hold_w),
  .flags_o      (flags_o),
  .test_flags_o (test_flags_o)
);

// File: tb/cmp_capture_router_tb.sv
module cmp_capture_router_tb;
  logic clk = 1'b0;
  logic rst, cmp_a, cmp_b, inv_a, inv_b, arm, stop, tmode, tslot, env;
  logic [1:0] chan;
  logic [7:0] flags;
  logic [1:0] tflags;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  bit       m_hold [2];
  bit [7:0] m_flags;
  bit [1:0] m_test;
  bit       m_prev;

  always #5 clk = ~clk;

  cmp_capture_router u_dut (
    .clk(clk), .rst(rst), .cmp_a_i(cmp_a), .cmp_b_i(cmp_b),
    .inv_a_i(inv_a), .inv_b_i(inv_b), .arm_i(arm), .stop_i(stop),
    .chan_i(chan), .test_mode_i(tmode), .test_slot_i(tslot),
    .env_mode_i(env), .flags_o(flags), .test_flags_o(tflags)
  );

  task automatic model_step();
    bit e0, e1;
    int c;
    c = int'(chan);
    if (rst) begin
      m_hold[0] = 0; m_hold[1] = 0; m_flags = 0; m_test = 0; m_prev = 0;
      return;
    end
    if (stop && !m_prev) begin
      if (tmode) m_test[tslot] = m_hold[0];
      else begin
        m_flags[c] = m_hold[0];
        if (!env) m_flags[4 + c] = m_hold[1];
      end
    end
    e0 = cmp_a ^ inv_a;
    e1 = cmp_b ^ inv_b;
    m_hold[0] = arm ? (m_hold[0] | e0) : 1'b0;
    m_hold[1] = arm ? (m_hold[1] | e1) : 1'b0;
    m_prev = stop;
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    model_step();
    #2;
    checks++;
    if (flags !== m_flags) begin
      errors++;
      $display("FAIL %s flags actual=%b expected=%b t=%0t", tag, flags, m_flags, $time);
    end
    checks++;
    if (tflags !== m_test) begin
      errors++;
      $display("FAIL %s test_flags actual=%b expected=%b t=%0t", tag, tflags, m_test, $time);
    end
  endtask

  task automatic expect_lit(input string tag, input logic [7:0] ef, input logic [1:0] et);
    checks++;
    if (flags !== ef || tflags !== et) begin
      errors++;
      $display("FAIL %s literal actual=%b/%b expected=%b/%b", tag, flags, tflags, ef, et);
    end
  endtask

  // one slot: arm window with given comparator values, then a stop pulse
  task automatic slot(input string tag, input bit a, input bit b, input int win);
    arm = 1; cmp_a = a; cmp_b = b;
    for (int i = 0; i < win; i++) tick(tag);
    cmp_a = 0; cmp_b = 0; arm = 0; stop = 1;
    tick(tag);
    stop = 0;
    tick(tag);
  endtask

  initial begin
    rst = 1; cmp_a = 0; cmp_b = 0; inv_a = 0; inv_b = 0; arm = 0; stop = 0;
    chan = 0; tmode = 0; tslot = 0; env = 0;
    tick("R1"); tick("R1");
    expect_lit("R1", 8'h00, 2'b00);
    rst = 0;
    tick("R1");

    // R5 normal routing over all codes, differing patterns per front-end
    for (int c = 0; c < 4; c++) begin
      chan = 2'(c);
      slot("R5", 1'b1, c[0], 2 + c);
    end
    expect_lit("R5", 8'hAF, 2'b00);

    // R2 short comparator pulse inside a long window is kept
    chan = 1;
    arm = 1; cmp_a = 0; cmp_b = 0; tick("R2");
    cmp_a = 1; tick("R2"); cmp_a = 0;
    for (int i = 0; i < 3; i++) tick("R2");
    arm = 0; stop = 1; tick("R2"); stop = 0; tick("R2");
    expect_lit("R2", 8'h8F, 2'b00);

    // R3 inversion on front-end 2 only
    inv_b = 1; chan = 0;
    slot("R3", 1'b0, 1'b0, 2);
    expect_lit("R3", 8'h9E, 2'b00);
    inv_b = 0;

    // R4 stop held high: single write only
    chan = 3; arm = 1; cmp_a = 0; tick("R4");
    arm = 0; stop = 1; tick("R4");
    arm = 1; cmp_a = 1; cmp_b = 1;
    for (int i = 0; i < 4; i++) tick("R4");
    arm = 0; tick("R4"); stop = 0; tick("R4");
    expect_lit("R4", 8'h16, 2'b00);

    // R6 test mode: code ignored, both slots; R8 afterwards
    tmode = 1; env = 1;
    for (int s = 0; s < 2; s++) begin
      tslot = 1'(s); chan = 2'(3 - s);
      slot("R6", 1'b1, 1'b1, 2);
    end
    expect_lit("R6", 8'h16, 2'b11);
    tslot = 0; slot("R6", 1'b0, 1'b1, 2);
    expect_lit("R6", 8'h16, 2'b10);

    // R7 envelope: lower flags by code, upper untouched
    tmode = 0; env = 1;
    for (int c = 0; c < 4; c++) begin
      chan = 2'(c);
      slot("R7", ~c[1], 1'b1, 1);
    end
    expect_lit("R7", 8'h13, 2'b10);
    env = 0;

    // R8 normal-mode writes leave test flags
    slot("R8", 1'b1, 1'b1, 2);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      rst   = ($urandom_range(0, 199) == 0);
      cmp_a = 1'($urandom); cmp_b = 1'($urandom);
      inv_a = ($urandom_range(0, 7) == 0); inv_b = ($urandom_range(0, 7) == 0);
      arm   = ($urandom_range(0, 3) != 0);
      stop  = ($urandom_range(0, 2) == 0);
      chan  = 2'($urandom); tslot = 1'($urandom);
      tmode = ($urandom_range(0, 3) == 0); env = ($urandom_range(0, 3) == 0);
      tick("R4");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL R4 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule